// File: doc/BRIEF.md
# Up/Down Timer with Capture and Reload

This block is a 16-bit timer/counter for a microcontroller-style peripheral set. It advances either on a machine-cycle tick (one tick per 12 oscillator periods, supplied as a clock enable) or on falling edges seen on an external count pin. A 16-bit reload/capture register works alongside the count. In reload mode an overflow copies that register into the count. In capture mode a trigger edge copies the running count into that register.

A second external pin, the trigger pin, has two roles. In capture mode, and in plain reload mode, its falling edge is the capture or reload trigger. In direction mode, its level chooses whether the count runs up or down. When counting down, the count wraps to 0xFFFF once it reaches the reload value.

Software reaches the block through a byte-wide register port. The write side is synchronous and the read side is combinational. The map is:

- Address 0: count low byte.
- Address 1: count high byte.
- Address 2: reload/capture low byte.
- Address 3: reload/capture high byte.
- Address 4: control byte.
  - Bit 0: run.
  - Bit 1: external count source.
  - Bit 2: capture mode.
  - Bit 3: trigger enable.
  - Bit 4: direction mode.
  - Bit 7: overflow flag.

Unmapped addresses read as zero. An overflow raises a sticky flag, which also drives the `ovf_flag` output.

Top module: `updn_cap_timer`

## Requirements
- R1: After reset, the count, the reload register and the control byte read as zero, and the overflow flag is 0.
- R2: With run set and the internal source selected (control bit 1 = 0), the count rises by exactly one per cycle in which `tick` is high, and holds when `tick` is low.
- R3: With the external source selected (control bit 1 = 1), the count rises by one on each tick where the count pin was sampled high on the previous tick and is low on this tick. A pin held low, or held high, across ticks adds nothing.
- R4: With run clear (control bit 0 = 0), the count does not change on ticks.
- R5: In reload mode (control bits 2 and 4 both 0), an upward step from 0xFFFF loads the reload value and sets the overflow flag.
- R6: In capture mode (control bit 2 = 1), an upward step from 0xFFFF wraps to 0x0000 and sets the flag. With trigger enable set (control bit 3 = 1), a trigger falling edge (sampled on ticks like R3) copies the current count into the reload register.
- R7: In direction mode (control bit 4 = 1, bit 2 = 0), a high trigger pin counts up and a low pin counts down. A downward step from a count equal to the reload value loads 0xFFFF and sets the flag. An upward step from 0xFFFF loads the reload value and sets the flag.
- R8: In reload mode with trigger enable set and direction mode clear, a trigger falling edge loads the count from the reload register without setting the flag, even with run clear.
- R9: With trigger enable clear, trigger edges change neither the count nor the reload register.
- R10: A software write to a count byte takes priority over any step in the same cycle. That byte takes the written value, the other byte holds, and no overflow occurs. A write to a reload byte takes priority over a capture into that byte.
- R11: The overflow flag stays set until a control write with bit 7 = 0. A control write with bit 7 = 1 leaves it unchanged. An overflow in the same cycle as a clearing write leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Machine-cycle clock enable |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Capture/reload trigger or direction select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets these corner cases:

- The wrap boundaries: 0xFFFF going up in each mode, and count equal to reload going down. A design that wraps to zero in reload mode, or that decrements through the reload value, leaves a wrong count at those points.
- Edge detection with a pin held low across several ticks. A level-sensitive design would count on every one of those ticks.
- Same-cycle collisions: a count write against a tick, a reload write against a capture, and a flag clear against an overflow. A wrong priority shows up as an incremented count, a captured byte where the written one belongs, or a lost flag.
- Trigger edges with the trigger enable clear. A design that ignores the enable would alter the count or the reload register.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

    typedef enum logic [1:0] {
        MODE_RLD_UP   = 2'd0,
        MODE_RLD_UPDN = 2'd1,
        MODE_CAPTURE  = 2'd2
    } tmr_mode_e;

    localparam int CTL_RUN  = 0;
    localparam int CTL_EXT  = 1;
    localparam int CTL_CAP  = 2;
    localparam int CTL_TRG  = 3;
    localparam int CTL_DIR  = 4;
    localparam int CTL_W    = 5;
    localparam int CTL_FLAG = 7;

endpackage

// File: rtl/updn_edge_det.sv
module updn_edge_det #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NPIN-1:0] pin,
    output logic [NPIN-1:0] fall
);

    logic [NPIN-1:0] smp_q;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q[i] <= 1'b0;
            end else if (tick) begin
                smp_q[i] <= pin[i];
            end
        end

        assign fall[i] = tick & smp_q[i] & ~pin[i];

        // R3: a falling edge needs a fresh high sample, so two in a row are impossible
        a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]);
    end

endmodule

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
    import updn_tmr_pkg::*;
(
    input  logic [CTL_W-1:0] ctl,
    input  logic             tick,
    input  logic             cnt_fall,
    input  logic             trig_fall,
    input  logic             trig_lvl,
    output tmr_mode_e        mode,
    output logic             step,
    output logic             dir_up,
    output logic             trig_act
);

    always_comb begin
        if (ctl[CTL_CAP]) begin
            mode = MODE_CAPTURE;
        end else if (ctl[CTL_DIR]) begin
            mode = MODE_RLD_UPDN;
        end else begin
            mode = MODE_RLD_UP;
        end
    end

    always_comb begin
        step     = ctl[CTL_RUN] & (ctl[CTL_EXT] ? cnt_fall : tick);
        dir_up   = (mode == MODE_RLD_UPDN) ? trig_lvl : 1'b1;
        trig_act = ctl[CTL_TRG] & trig_fall & (mode != MODE_RLD_UPDN);
    end

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  tmr_mode_e        mode,
    input  logic             step,
    input  logic             dir_up,
    input  logic             trig_act,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] rld_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             load,
    output logic             ovf_evt,
    output logic             cap_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_comb begin
        cnt_nxt = cnt_q;
        load    = 1'b0;
        ovf_evt = 1'b0;
        cap_evt = 1'b0;
        unique case (mode)
            MODE_CAPTURE: begin
                cap_evt = trig_act;
                if (step) begin
                    load = 1'b1;
                    if (cnt_q == CNT_MAX) begin
                        cnt_nxt = '0;
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q + CNT_ONE;
                    end
                end
            end
            MODE_RLD_UP: begin
                if (trig_act) begin
                    load    = 1'b1;
                    cnt_nxt = rld_q;
                end else if (step) begin
                    load = 1'b1;
                    if (cnt_q == CNT_MAX) begin
                        cnt_nxt = rld_q;
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q + CNT_ONE;
                    end
                end
            end
            MODE_RLD_UPDN: begin
                if (step) begin
                    load = 1'b1;
                    if (dir_up) begin
                        if (cnt_q == CNT_MAX) begin
                            cnt_nxt = rld_q;
                            ovf_evt = 1'b1;
                        end else begin
                            cnt_nxt = cnt_q + CNT_ONE;
                        end
                    end else if (cnt_q == rld_q) begin
                        cnt_nxt = CNT_MAX;
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_nxt = cnt_q - CNT_ONE;
                    end
                end
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/updn_cap_timer.sv
module updn_cap_timer
    import updn_tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf_flag
);

    localparam int NB = CNT_W / DATA_W;
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(2 * NB);

    logic [CNT_W-1:0] cnt_q, rld_q, cnt_nxt;
    logic [CTL_W-1:0] ctl_q;
    logic             ovf_q;
    logic [NB-1:0]    cnt_wr_b, rld_wr_b;
    logic             cnt_wr, ctl_wr, ovf_set;
    logic [1:0]       pin_fall;
    tmr_mode_e        mode;
    logic             step, dir_up, trig_act, load, ovf_evt, cap_evt;
    logic             unused_wd;

    assign unused_wd = ^wr_data[DATA_W-2:CTL_W];

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            cnt_wr_b[b] = wr_en && (wr_addr == ADDR_W'(b));
            rld_wr_b[b] = wr_en && (wr_addr == ADDR_W'(NB + b));
        end
        cnt_wr  = |cnt_wr_b;
        ctl_wr  = wr_en && (wr_addr == CTL_ADDR);
        ovf_set = ovf_evt && !cnt_wr;
    end

    updn_edge_det #(.NPIN(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .pin   ({trig_pin, cnt_pin}),
        .fall  (pin_fall)
    );

    updn_mode_dec u_dec (
        .ctl       (ctl_q),
        .tick      (tick),
        .cnt_fall  (pin_fall[0]),
        .trig_fall (pin_fall[1]),
        .trig_lvl  (trig_pin),
        .mode      (mode),
        .step      (step),
        .dir_up    (dir_up),
        .trig_act  (trig_act)
    );

    updn_count_core #(.CNT_W(CNT_W)) u_core (
        .mode     (mode),
        .step     (step),
        .dir_up   (dir_up),
        .trig_act (trig_act),
        .cnt_q    (cnt_q),
        .rld_q    (rld_q),
        .cnt_nxt  (cnt_nxt),
        .load     (load),
        .ovf_evt  (ovf_evt),
        .cap_evt  (cap_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (cnt_wr_b[b]) begin
                    cnt_q[b*DATA_W +: DATA_W] <= wr_data;
                end else if (!cnt_wr && load) begin
                    cnt_q[b*DATA_W +: DATA_W] <= cnt_nxt[b*DATA_W +: DATA_W];
                end
                if (rld_wr_b[b]) begin
                    rld_q[b*DATA_W +: DATA_W] <= wr_data;
                end else if (cap_evt) begin
                    rld_q[b*DATA_W +: DATA_W] <= cnt_q[b*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_q <= wr_data[CTL_W-1:0];
            end
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end else if (ctl_wr && !wr_data[CTL_FLAG]) begin
                ovf_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == ADDR_W'(b)) begin
                rd_data = cnt_q[b*DATA_W +: DATA_W];
            end
            if (rd_addr == ADDR_W'(NB + b)) begin
                rd_data = rld_q[b*DATA_W +: DATA_W];
            end
        end
        if (rd_addr == CTL_ADDR) begin
            rd_data[CTL_W-1:0] = ctl_q;
            rd_data[CTL_FLAG]  = ovf_q;
        end
    end

    assign ovf_flag = ovf_q;

    // R4: stopped timer holds unless software or a trigger reload touches it
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CTL_RUN] && !cnt_wr && !(trig_act && mode != MODE_CAPTURE))
        |=> $stable(cnt_q));

    // R5: upward wrap in reload mode loads the reload value and raises the flag
    a_r5_up_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RLD_UP && step && !trig_act && !cnt_wr && cnt_q == '1)
        |=> (cnt_q == $past(rld_q) && ovf_q));

    // R6: upward wrap in capture mode goes to zero and raises the flag
    a_r6_cap_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAPTURE && step && !cnt_wr && cnt_q == '1)
        |=> (cnt_q == '0 && ovf_q));

    // R7: downward step at the reload value gives all ones and raises the flag
    a_r7_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RLD_UPDN && step && !dir_up && !cnt_wr && cnt_q == rld_q)
        |=> (cnt_q == '1 && ovf_q));

    // R10: a low-byte count write wins over any step
    a_r10_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_b[0] |=> cnt_q[DATA_W-1:0] == $past(wr_data));

    // R11: flag stays set unless a clearing control write arrives
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(ctl_wr && !wr_data[CTL_FLAG])) |=> ovf_q);

endmodule

// File: tb/sim_updn_cap_timer.sv
module sim_updn_cap_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       trig_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_cap_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_pin  (cnt_pin),
        .trig_pin (trig_pin),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ovf_flag (ovf_flag)
    );

    // entry: start count, reload, ticks, expected count, expected flag
    localparam logic [56:0] VEC [6] = '{
        {16'h0000, 16'h0000, 8'd5, 16'h0005, 1'b0},
        {16'hFFFE, 16'h1234, 8'd1, 16'hFFFF, 1'b0},
        {16'hFFFE, 16'h1234, 8'd2, 16'h1234, 1'b1},
        {16'hFFFF, 16'h8000, 8'd3, 16'h8002, 1'b1},
        {16'h00FF, 16'h0000, 8'd1, 16'h0100, 1'b0},
        {16'hFFFF, 16'hFFFF, 8'd2, 16'hFFFF, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] base, output logic [15:0] v);
        rd_addr = base;
        #1 v[7:0] = rd_data;
        rd_addr = base + 3'd1;
        #1 v[15:8] = rd_data;
    endtask

    task automatic set16(input logic [2:0] base, input logic [15:0] v);
        wr_reg(base, v[7:0]);
        wr_reg(base + 3'd1, v[15:8]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd16(3'd0, v); check("R1 count", v, 16'h0000);
        rd16(3'd2, v); check("R1 reload", v, 16'h0000);
        rd_addr = 3'd4; #1 c = rd_data;
        check("R1 control", {8'h00, c}, 16'h0000);
        check("R1 flag", {15'd0, ovf_flag}, 16'h0000);

        // R2 / R5 vector table in reload mode, internal source
        foreach (VEC[i]) begin
            wr_reg(3'd4, 8'h00);
            set16(3'd0, VEC[i][56:41]);
            set16(3'd2, VEC[i][40:25]);
            wr_reg(3'd4, 8'h01);
            repeat (int'(VEC[i][24:17])) pulse_tick();
            @(negedge clk);
            rd16(3'd0, v); check("R2_R5 vector count", v, VEC[i][16:1]);
            check("R5 vector flag", {15'd0, ovf_flag}, {15'd0, VEC[i][0]});
        end

        // R2: idle cycles without tick add nothing
        wr_reg(3'd4, 8'h01);
        set16(3'd0, 16'h0010);
        repeat (5) @(negedge clk);
        rd16(3'd0, v); check("R2 no tick", v, 16'h0010);

        // R4 run clear holds
        wr_reg(3'd4, 8'h00);
        repeat (3) pulse_tick();
        rd16(3'd0, v); check("R4 stopped", v, 16'h0010);

        // R3 counter mode
        set16(3'd0, 16'h0000);
        wr_reg(3'd4, 8'h03);
        cnt_pin = 1'b1; pulse_tick();
        rd16(3'd0, v); check("R3 high no count", v, 16'h0000);
        cnt_pin = 1'b0; pulse_tick();
        rd16(3'd0, v); check("R3 first edge", v, 16'h0001);
        pulse_tick(); pulse_tick();
        rd16(3'd0, v); check("R3 low held", v, 16'h0001);
        cnt_pin = 1'b1; pulse_tick();
        cnt_pin = 1'b0; pulse_tick();
        rd16(3'd0, v); check("R3 second edge", v, 16'h0002);

        // R6 capture-mode wrap and capture
        wr_reg(3'd4, 8'h00);
        set16(3'd0, 16'hFFFF);
        wr_reg(3'd4, 8'h05);
        pulse_tick();
        rd16(3'd0, v); check("R6 wrap zero", v, 16'h0000);
        check("R6 flag", {15'd0, ovf_flag}, 16'h0001);
        wr_reg(3'd4, 8'h0C);
        set16(3'd0, 16'h1234);
        set16(3'd2, 16'h0000);
        trig_pin = 1'b1; pulse_tick();
        trig_pin = 1'b0; pulse_tick();
        rd16(3'd2, v); check("R6 captured", v, 16'h1234);
        rd16(3'd0, v); check("R6 count kept", v, 16'h1234);

        // R9 trigger enable clear
        wr_reg(3'd4, 8'h04);
        set16(3'd0, 16'h5555);
        trig_pin = 1'b1; pulse_tick();
        trig_pin = 1'b0; pulse_tick();
        rd16(3'd2, v); check("R9 no capture", v, 16'h1234);
        wr_reg(3'd4, 8'h00);
        trig_pin = 1'b1; pulse_tick();
        trig_pin = 1'b0; pulse_tick();
        rd16(3'd0, v); check("R9 no reload", v, 16'h5555);

        // R8 trigger reload, run clear
        set16(3'd0, 16'h7777);
        set16(3'd2, 16'h0100);
        wr_reg(3'd4, 8'h08);
        trig_pin = 1'b1; pulse_tick();
        trig_pin = 1'b0; pulse_tick();
        rd16(3'd0, v); check("R8 reload", v, 16'h0100);
        check("R8 no flag", {15'd0, ovf_flag}, 16'h0000);

        // R7 direction mode
        wr_reg(3'd4, 8'h00);
        set16(3'd0, 16'h0102);
        trig_pin = 1'b0;
        wr_reg(3'd4, 8'h11);
        pulse_tick(); pulse_tick();
        rd16(3'd0, v); check("R7 down", v, 16'h0100);
        check("R7 no flag yet", {15'd0, ovf_flag}, 16'h0000);
        pulse_tick();
        rd16(3'd0, v); check("R7 down wrap", v, 16'hFFFF);
        check("R7 down flag", {15'd0, ovf_flag}, 16'h0001);
        wr_reg(3'd4, 8'h11);
        trig_pin = 1'b1; pulse_tick();
        rd16(3'd0, v); check("R7 up wrap", v, 16'h0100);
        check("R7 up flag", {15'd0, ovf_flag}, 16'h0001);
        trig_pin = 1'b0;

        // R11 flag write of one keeps it, zero clears it
        wr_reg(3'd4, 8'h80);
        check("R11 keep", {15'd0, ovf_flag}, 16'h0001);
        wr_reg(3'd4, 8'h00);
        check("R11 clear", {15'd0, ovf_flag}, 16'h0000);

        // R10 count write against tick
        set16(3'd0, 16'h00FF);
        wr_reg(3'd4, 8'h01);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h42;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd16(3'd0, v); check("R10 write beats step", v, 16'h0042);

        // R10 reload write against capture
        wr_reg(3'd4, 8'h0C);
        set16(3'd0, 16'hABCD);
        set16(3'd2, 16'h0000);
        trig_pin = 1'b1; pulse_tick();
        @(negedge clk);
        trig_pin = 1'b0; tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h99;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd16(3'd2, v); check("R10 write beats capture", v, 16'hAB99);

        // R11 overflow wins over a same-cycle clear
        wr_reg(3'd4, 8'h00);
        set16(3'd0, 16'hFFFF);
        set16(3'd2, 16'h0000);
        wr_reg(3'd4, 8'h01);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        check("R11 set wins", {15'd0, ovf_flag}, 16'h0001);
        rd16(3'd0, v); check("R11 count reloaded", v, 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule